// File: doc/BRIEF.md
# Condition-Code Setting ALU

This block is the integer execute stage of a small processor. It computes a 32-bit result from two operands using one of six operations: add, add with carry, subtract, AND, OR and XOR. From that result it derives four condition flags: negative, zero, signed overflow and carry. The flags are kept in a register, so that a later conditional branch or a chained add can read them.

The result path is combinational. The flag register loads on a clock edge while the flag-write enable is high. The flags leave the block as a four-bit bus. They also appear as a field at bits 23:20 of a 32-bit processor status word.

A discard input supports instructions whose destination throws the value away. Compare is a subtract in this mode, test is an OR with zero, and bit-test is an AND. With discard high the result port reads zero, but the flags still follow the computed value.

Top module: `cc_alu`

## Requirements
- R1: Opcode 3'd0 (add) outputs a + b modulo 2^32. When the flags are written, C takes the carry out of bit 31.
- R2: Opcode 3'd1 (add with carry) outputs a + b + C, where C is the stored carry flag. C and V are updated as for add, so an add of the low words followed by this opcode on the high words gives the 64-bit sum.
- R3: Opcode 3'd2 (subtract) outputs a - b modulo 2^32. C is set when the subtraction borrows, which happens when b > a as unsigned numbers.
- R4: For opcodes 0, 1 and 2, V is set when the true signed result does not fit in 32 signed bits.
- R5: N takes bit 31 of the computed value, and Z is set exactly when all 32 bits of the computed value are zero.
- R6: Opcodes 3'd3 (AND), 3'd4 (OR) and 3'd5 (XOR) output the bitwise function and clear V and C.
- R7: The flags change only on a rising clock edge with flag_we high. At any other time they hold their value.
- R8: Synchronous active-high reset clears all four flags to 0.
- R9: With discard high, the result output is zero. A write then still loads the flags from the computed value, which gives compare (subtract), test (OR with 0) and bit-test (AND).
- R10: The status word carries N at bit 23, Z at bit 22, V at bit 21 and C at bit 20. All other bits read zero.
- R11: Opcodes 3'd6 and 3'd7 are no-operations: the result reads zero and the flags hold even when flag_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 3 | Operation code |
| flag_we | input | 1 | Load the flags at the next edge |
| discard | input | 1 | Flag-only mode: the result port is forced to zero |
| result | output | 32 | Computed value, combinational |
| flags | output | 4 | Stored flags {N,Z,V,C} |
| psw | output | 32 | Status word with the flags at bits 23:20 |

## Verification
The hardest case to reach is the add with carry, because its carry-in comes from state left by an earlier operation. The bench sets up that state with an add of the low words, or with a subtract that borrows, and then issues add with carry on the high words. It compares the combined 64-bit result against a wide sum. Signed overflow needs operands at the edges of the signed range, so every opcode runs over all pairs of 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF before the random operands.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
    localparam int DATA_W   = 32;
    localparam int PSW_W    = 32;
    localparam int FLAG_LSB = 20;
    localparam int FLAG_W   = 4;
    localparam int OP_W     = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUB  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    function automatic logic op_is_arith(input logic [OP_W-1:0] op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB);
    endfunction

    function automatic logic op_is_logic(input logic [OP_W-1:0] op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic op_is_valid(input logic [OP_W-1:0] op);
        return op_is_arith(op) || op_is_logic(op);
    endfunction
endpackage

// File: rtl/cc_addsub.sv
module cc_addsub
    import cc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    // Subtraction reuses the adder: a + ~b + 1.
    assign b_eff = sub ? ~b : b;
    assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    assign sum   = wide[W-1:0];
    assign cout  = wide[W];
    // Signed overflow: both addends share a sign that the sum does not.
    assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/cc_logic.sv
module cc_logic
    import cc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [OP_W-1:0]   op,
    output logic [W-1:0]      y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (op)
                OP_AND:  y[i] = a[i] & b[i];
                OP_OR:   y[i] = a[i] | b[i];
                OP_XOR:  y[i] = a[i] ^ b[i];
                default: y[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
    import cc_alu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  cc_t  d,
    output cc_t  q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
    import cc_alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   op_a,
    input  logic [DATA_W-1:0]   op_b,
    input  logic [OP_W-1:0]     op_sel,
    input  logic                flag_we,
    input  logic                discard,
    output logic [DATA_W-1:0]   result,
    output logic [FLAG_W-1:0]   flags,
    output logic [PSW_W-1:0]    psw
);
    cc_t               cc_q;
    cc_t               cc_d;
    logic              is_sub;
    logic              is_arith;
    logic              valid;
    logic              add_cin;
    logic [DATA_W-1:0] arith_y;
    logic [DATA_W-1:0] logic_y;
    logic [DATA_W-1:0] value;
    logic              add_cout;
    logic              add_ovf;

    assign is_sub   = (op_sel == OP_SUB);
    assign is_arith = op_is_arith(op_sel);
    assign valid    = op_is_valid(op_sel);
    assign add_cin  = is_sub ? 1'b1 : ((op_sel == OP_ADDC) ? cc_q.c : 1'b0);

    cc_addsub #(.W(DATA_W)) addsub_i (
        .a    (op_a),
        .b    (op_b),
        .sub  (is_sub),
        .cin  (add_cin),
        .sum  (arith_y),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    cc_logic #(.W(DATA_W)) logic_i (
        .a  (op_a),
        .b  (op_b),
        .op (op_sel),
        .y  (logic_y)
    );

    assign value = is_arith ? arith_y : logic_y;

    always_comb begin
        cc_d.n = value[DATA_W-1];
        cc_d.z = (value == '0);
        cc_d.v = is_arith & add_ovf;
        // Borrow is the inverse of the adder carry on subtract.
        cc_d.c = is_arith & (is_sub ? ~add_cout : add_cout);
    end

    cc_flag_reg flag_i (
        .clk (clk),
        .rst (rst),
        .we  (flag_we & valid),
        .d   (cc_d),
        .q   (cc_q)
    );

    assign result = (discard || !valid) ? '0 : value;
    assign flags  = cc_q;

    always_comb begin
        psw = '0;
        psw[FLAG_LSB +: FLAG_W] = cc_q;
    end
endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk
    import cc_alu_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [OP_W-1:0]     op_sel,
    input logic                flag_we,
    input logic                discard,
    input logic [DATA_W-1:0]   result,
    input logic [FLAG_W-1:0]   flags,
    input logic [PSW_W-1:0]    psw
);
    // R8
    reset_clear_chk: assert property (@(posedge clk) rst |=> flags == '0);

    // R7
    hold_no_we_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(flag_we)) |-> $stable(flags));

    // R11
    reserved_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !op_is_valid($past(op_sel))) |-> $stable(flags));

    // R9
    discard_zero_chk: assert property (@(posedge clk) disable iff (rst)
        discard |-> result == '0);

    // R6
    logic_vc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(flag_we) && !$past(rst) && op_is_logic($past(op_sel))) |-> flags[1:0] == 2'b00);

    // R5
    nz_track_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(flag_we) && !$past(rst) && !$past(discard) && op_is_valid($past(op_sel)))
        |-> (flags[3] == $past(result[DATA_W-1])) && (flags[2] == ($past(result) == '0)));

    // R10
    psw_field_chk: assert property (@(posedge clk) disable iff (rst)
        (psw[FLAG_LSB +: FLAG_W] == flags) && (psw[FLAG_LSB-1:0] == '0)
        && (psw[PSW_W-1:FLAG_LSB+FLAG_W] == '0));
endmodule

bind cc_alu cc_alu_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .op_sel  (op_sel),
    .flag_we (flag_we),
    .discard (discard),
    .result  (result),
    .flags   (flags),
    .psw     (psw)
);

// File: tb/cc_alu_tb.sv
module cc_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [2:0]  op_sel = '0;
    logic        flag_we = 1'b0;
    logic        discard = 1'b0;
    logic [31:0] result;
    logic [3:0]  flags;
    logic [31:0] psw;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [3:0]  mdl_flags = '0;
    logic [31:0] corners [4] = '{32'h0, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF};

    always #4 clk = ~clk;

    cc_alu dut_i (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .flag_we(flag_we), .discard(discard), .result(result),
        .flags(flags), .psw(psw)
    );

    // Reference: {valid, N, Z, V, C, value}
    function automatic logic [36:0] model(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic cin);
        logic [32:0] t;
        logic [31:0] r;
        logic        v, c;
        v = 1'b0; c = 1'b0; r = '0;
        case (op)
            3'd0, 3'd1: begin
                t = {1'b0, a} + {1'b0, b} + ((op == 3'd1) ? {32'd0, cin} : 33'd0);
                r = t[31:0]; c = t[32];
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            3'd2: begin
                t = {1'b0, a} - {1'b0, b};
                r = t[31:0]; c = (b > a);
                v = (a[31] != b[31]) && (r[31] != a[31]);
            end
            3'd3: r = a & b;
            3'd4: r = a | b;
            3'd5: r = a ^ b;
            default: return {1'b0, 4'b0, 32'b0};
        endcase
        return {1'b1, r[31], (r == 32'd0), v, c, r};
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3, 3'd4, 3'd5: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operation, check the result and then the stored flags and status word.
    task automatic apply(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic we, input logic disc, input string req);
        logic [36:0] m;
        @(negedge clk);
        op_sel = op; op_a = a; op_b = b; flag_we = we; discard = disc;
        m = model(op, a, b, mdl_flags[0]);
        #1;
        check(disc ? "R9" : req, result, (disc || !m[36]) ? 32'd0 : m[31:0]);
        if (we && m[36]) mdl_flags = m[35:32];
        @(posedge clk);
        #1;
        check((op <= 3'd2) ? {req, "/R4/R5"} : {req, "/R5"}, {28'd0, flags}, {28'd0, mdl_flags});
        check("R10", psw, {8'd0, mdl_flags, 20'd0});
        flag_we = 1'b0; discard = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mdl_flags = '0;
        check("R8", {28'd0, flags}, 32'd0);
        check("R10", psw, 32'd0);
    endtask

    task automatic t_corners();
        for (int op = 0; op < 6; op++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    apply(3'(op), corners[i], corners[j], 1'b1, 1'b0, req_of(3'(op)));
    endtask

    task automatic t_random();
        for (int k = 0; k < 300; k++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 5));
            apply(op, $urandom, $urandom, 1'b1, 1'b0, req_of(op));
        end
    endtask

    // R2: 64-bit sum from ADD low then ADDC high
    task automatic t_chain();
        for (int k = 0; k < 20; k++) begin
            logic [63:0] x, y, s, got;
            x = {$urandom, $urandom};
            y = {$urandom, $urandom};
            if (k == 0) begin x = 64'h0000_0001_FFFF_FFFF; y = 64'h1; end
            s = x + y;
            apply(3'd0, x[31:0], y[31:0], 1'b1, 1'b0, "R1");
            got[31:0] = 32'(x[31:0] + y[31:0]);
            @(negedge clk);
            op_sel = 3'd1; op_a = x[63:32]; op_b = y[63:32];
            #1;
            got[63:32] = result;
            check("R2", got[63:32], s[63:32]);
            check("R2", got[31:0], s[31:0]);
        end
        // A borrowing subtract leaves C=1, which the add with carry then adds in.
        apply(3'd2, 32'd1, 32'd2, 1'b1, 1'b0, "R3");
        apply(3'd1, 32'd10, 32'd20, 1'b1, 1'b0, "R2");
    endtask

    // R7: flags hold without a write
    task automatic t_hold();
        apply(3'd2, 32'd0, 32'd1, 1'b1, 1'b0, "R3");
        apply(3'd3, 32'd0, 32'd0, 1'b0, 1'b0, "R7");
        apply(3'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, "R7");
    endtask

    // R9: compare, test and bit-test through flag-only mode
    task automatic t_discard();
        apply(3'd2, 32'd55, 32'd55, 1'b1, 1'b1, "R9");
        check("R9", {28'd0, flags}, 32'h4);
        apply(3'd4, 32'h8000_0000, 32'd0, 1'b1, 1'b1, "R9");
        check("R9", {28'd0, flags}, 32'h8);
        apply(3'd3, 32'hF0, 32'h0F, 1'b1, 1'b1, "R9");
        check("R9", {28'd0, flags}, 32'h4);
    endtask

    // R11: reserved codes write nothing
    task automatic t_reserved();
        apply(3'd2, 32'h8000_0000, 32'd1, 1'b1, 1'b0, "R4");
        apply(3'd6, 32'd1, 32'd1, 1'b1, 1'b0, "R11");
        apply(3'd7, 32'd0, 32'd0, 1'b1, 1'b0, "R11");
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_corners();
        t_hold();
        t_discard();
        t_reserved();
        t_chain();
        t_random();
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule